// File: doc/BRIEF.md
# DSP Position-Conditional Compact Branch Unit

This unit sits in the decode stage. It recognises a compact conditional branch whose condition is the DSP position field. The branch goes when that unsigned field has reached 32. It works out the PC-relative destination for either of two instruction encodings: the standard one, or a compressed one whose 32-bit forms use half-word offset scaling. These branches have no delay slot.

The unit also tracks the forbidden slot. This is the one valid instruction that follows any control-transfer instruction. A control-transfer instruction that arrives in that slot gets a Reserved Instruction exception. The branch itself faults with a DSP Disabled exception when the DSP unit is switched off. That exception outranks the slot trap.

All results appear on registered outputs one cycle after the input strobe. Fetch, redirection of the PC and exception vectoring are left to the surrounding pipeline.

Top module: `posbr_top`

## Requirements
- R1: With `compactMode`=0, a word with bits 31:26=000001, 25:21=00000 and 20:16=11000 is the position branch. Its target is instPc+4 plus the sign-extended 16-bit offset (bits 15:0) shifted left by 2.
- R2: With `compactMode`=1, a word with bits 31:26=010000, 25:21=11001 and 20:16=00000 is the position branch. Its target is instPc+4 plus the sign-extended offset shifted left by 1.
- R3: A recognised, non-faulting position branch drives `brTaken`=1 exactly when `dspPos`, read as a 7-bit unsigned value, is 32 or more.
- R4: Outputs are registered. `outValid` follows `instValid` by one cycle. When `outValid` is 0, `brTaken`, `excDspOff` and `excResInst` are 0.
- R5: A control-transfer instruction that is the next valid instruction after a non-faulting control-transfer instruction raises `excResInst`. Cycles with `instValid` low between the two do not close the slot. In that case `excCause`=2 and `excPc` equals the PC of the trapped instruction.
- R6: The next valid instruction closes the forbidden slot. A non-control-transfer instruction in the slot raises nothing, and a later control-transfer instruction is then accepted.
- R7: A position branch with `dspEnable`=0 raises `excDspOff` with `excCause`=1 and `excPc` set to its PC. This exception takes priority over the slot trap, so `excResInst` stays 0.
- R8: `brTaken` is 0 whenever either exception flag is raised.
- R9: The control-transfer set in standard mode covers these words:
  - major opcodes 000001 to 000111;
  - opcode 000000 with function 001000 or 001001;
  - the word 0x00000140;
  - opcode 010000 with bit 25 set and function 011000, 011111 or 100000.
- R10: In compressed mode, the control-transfer set is major opcodes 010000, 100101, 110101 and 111101.
- R11: Reset clears all outputs to zero and closes the forbidden slot.
- R12: Target arithmetic is 32 bits wide and wraps modulo 2^32.
- R13: An instruction that raises an exception does not open a forbidden slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction strobe |
| instWord | input | 32 | Instruction word |
| instPc | input | 32 | Address of the instruction |
| compactMode | input | 1 | 1 = compressed encoding, 0 = standard |
| dspPos | input | 7 | DSP position field |
| dspEnable | input | 1 | DSP unit enabled |
| outValid | output | 1 | Result valid |
| brTaken | output | 1 | Branch taken |
| brTarget | output | 32 | Branch destination |
| excDspOff | output | 1 | DSP Disabled exception |
| excResInst | output | 1 | Reserved Instruction exception |
| excCause | output | 2 | 0 none, 1 DSP disabled, 2 reserved instruction |
| excPc | output | 32 | PC of the faulting instruction |

## Verification
The only hidden state is the forbidden-slot flag. A flag stuck high shows up at the ports on the very next control-transfer instruction, as a spurious `excResInst` one cycle after its strobe. A flag stuck low lets the second of two back-to-back control-transfer instructions through with no exception. A wrong threshold or wrong offset scaling shows up in the same cycle's registered `brTaken` or `brTarget`. The bench sweeps every position value under both encodings to expose these.

// File: rtl/posbr_pkg.sv
package posbr_pkg;

  typedef struct packed {
    logic ldStrb;
    logic takeStrb;
    logic dspExc;
    logic riExc;
  } posbr_strb_t;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_DSP_OFF  = 2'd1,
    CAUSE_RES_INST = 2'd2
  } posbr_cause_e;

  localparam logic [5:0] STD_REGIMM_OP = 6'b000001;
  localparam logic [4:0] STD_POS_RT    = 5'b11000;
  localparam logic [5:0] CMP_POOL_OP   = 6'b010000;
  localparam logic [4:0] CMP_POS_RS    = 5'b11001;

endpackage

// File: rtl/posbr_ctrl.sv
module posbr_ctrl
  import posbr_pkg::*;
#(
  parameter int POS_W     = 7,
  parameter int POS_LIMIT = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instValid,
  input  logic [31:0]      instWord,
  input  logic             compactMode,
  input  logic [POS_W-1:0] dspPos,
  input  logic             dspEnable,
  output posbr_strb_t      strb
);

  logic [5:0] opField;
  logic [4:0] rsField, rtField;
  logic [5:0] fnField;
  logic       isPosBranch;
  logic       isCtiStd, isCtiCmp, isCti;
  logic       slotOpen;
  logic       dspTrap, riTrap, condMet;

  assign opField = instWord[31:26];
  assign rsField = instWord[25:21];
  assign rtField = instWord[20:16];
  assign fnField = instWord[5:0];

  always_comb begin
    if (compactMode)
      isPosBranch = (opField == CMP_POOL_OP) && (rsField == CMP_POS_RS) && (rtField == 5'd0);
    else
      isPosBranch = (opField == STD_REGIMM_OP) && (rsField == 5'd0) && (rtField == STD_POS_RT);
  end

  always_comb begin
    isCtiStd = 1'b0;
    if (opField >= 6'b000001 && opField <= 6'b000111) isCtiStd = 1'b1;
    if (opField == 6'b000000 && (fnField == 6'b001000 || fnField == 6'b001001)) isCtiStd = 1'b1;
    if (instWord == 32'h0000_0140) isCtiStd = 1'b1;
    if (opField == 6'b010000 && instWord[25] &&
        (fnField == 6'b011000 || fnField == 6'b011111 || fnField == 6'b100000)) isCtiStd = 1'b1;
  end

  always_comb begin
    unique case (opField)
      6'b010000, 6'b100101, 6'b110101, 6'b111101: isCtiCmp = 1'b1;
      default:                                    isCtiCmp = 1'b0;
    endcase
  end

  assign isCti   = compactMode ? isCtiCmp : isCtiStd;
  assign condMet = ({1'b0, dspPos} >= (POS_W+1)'(POS_LIMIT));
  assign dspTrap = instValid && isPosBranch && !dspEnable;
  assign riTrap  = instValid && slotOpen && isCti && !dspTrap;

  always_ff @(posedge clk) begin
    if (!rstN)
      slotOpen <= 1'b0;
    else if (instValid)
      slotOpen <= isCti && !dspTrap && !riTrap;
  end

  always_comb begin
    strb.ldStrb   = instValid;
    strb.dspExc   = dspTrap;
    strb.riExc    = riTrap;
    strb.takeStrb = instValid && isPosBranch && condMet && !dspTrap && !riTrap;
  end

endmodule

// File: rtl/posbr_dpath.sv
module posbr_dpath
  import posbr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  posbr_strb_t       strb,
  input  logic [OFF_W-1:0]  offField,
  input  logic              compactMode,
  input  logic [ADDR_W-1:0] instPc,
  output logic              outValid,
  output logic              brTaken,
  output logic [ADDR_W-1:0] brTarget,
  output logic              excDspOff,
  output logic              excResInst,
  output logic [1:0]        excCause,
  output logic [ADDR_W-1:0] excPc
);

  localparam int SHIFT_STD = 2;
  localparam int SHIFT_CMP = 1;
  localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(4);

  logic [ADDR_W-1:0] dispStd, dispCmp, dispSel, nextTarget;
  posbr_cause_e      causeNext;

  assign dispStd = {{(ADDR_W-OFF_W-SHIFT_STD){offField[OFF_W-1]}}, offField, {SHIFT_STD{1'b0}}};
  assign dispCmp = {{(ADDR_W-OFF_W-SHIFT_CMP){offField[OFF_W-1]}}, offField, {SHIFT_CMP{1'b0}}};
  assign dispSel = compactMode ? dispCmp : dispStd;
  assign nextTarget = instPc + INSN_BYTES + dispSel;

  always_comb begin
    if (strb.dspExc)     causeNext = CAUSE_DSP_OFF;
    else if (strb.riExc) causeNext = CAUSE_RES_INST;
    else                 causeNext = CAUSE_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      brTaken    <= 1'b0;
      brTarget   <= '0;
      excDspOff  <= 1'b0;
      excResInst <= 1'b0;
      excCause   <= 2'd0;
      excPc      <= '0;
    end else begin
      outValid   <= strb.ldStrb;
      brTaken    <= strb.takeStrb;
      excDspOff  <= strb.dspExc;
      excResInst <= strb.riExc;
      excCause   <= causeNext;
      if (strb.ldStrb) begin
        brTarget <= nextTarget;
        excPc    <= instPc;
      end
    end
  end

endmodule

// File: rtl/posbr_top.sv
module posbr_top
  import posbr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int POS_W     = 7,
  parameter int POS_LIMIT = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [31:0]       instWord,
  input  logic [ADDR_W-1:0] instPc,
  input  logic              compactMode,
  input  logic [POS_W-1:0]  dspPos,
  input  logic              dspEnable,
  output logic              outValid,
  output logic              brTaken,
  output logic [ADDR_W-1:0] brTarget,
  output logic              excDspOff,
  output logic              excResInst,
  output logic [1:0]        excCause,
  output logic [ADDR_W-1:0] excPc
);

  posbr_strb_t strb;

  posbr_ctrl #(.POS_W(POS_W), .POS_LIMIT(POS_LIMIT)) ctrl_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .compactMode(compactMode), .dspPos(dspPos), .dspEnable(dspEnable), .strb(strb)
  );

  posbr_dpath #(.ADDR_W(ADDR_W), .OFF_W(16)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .offField(instWord[15:0]),
    .compactMode(compactMode), .instPc(instPc), .outValid(outValid),
    .brTaken(brTaken), .brTarget(brTarget), .excDspOff(excDspOff),
    .excResInst(excResInst), .excCause(excCause), .excPc(excPc)
  );

endmodule

// File: rtl/posbr_checker.sv
module posbr_checker #(
  parameter int ADDR_W    = 32,
  parameter int POS_W     = 7,
  parameter int POS_LIMIT = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              instValid,
  input logic [ADDR_W-1:0] instPc,
  input logic [POS_W-1:0]  dspPos,
  input logic              dspEnable,
  input logic              outValid,
  input logic              brTaken,
  input logic              excDspOff,
  input logic              excResInst,
  input logic [1:0]        excCause,
  input logic [ADDR_W-1:0] excPc
);

  p_valid_lag_r4: assert property (@(posedge clk) disable iff (!rstN)
    instValid |=> outValid);

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!brTaken && !excDspOff && !excResInst));

  p_taken_pos_r3: assert property (@(posedge clk) disable iff (!rstN)
    brTaken |-> ({1'b0, $past(dspPos)} >= (POS_W+1)'(POS_LIMIT)));

  p_taken_no_exc_r8: assert property (@(posedge clk) disable iff (!rstN)
    brTaken |-> (!excDspOff && !excResInst));

  p_dsp_off_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    excDspOff |-> (excCause == 2'd1 && !excResInst && !$past(dspEnable)));

  p_ri_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    excResInst |-> (excCause == 2'd2));

  p_exc_pc_r5: assert property (@(posedge clk) disable iff (!rstN)
    (excDspOff || excResInst) |-> (excPc == $past(instPc)));

endmodule

bind posbr_top posbr_checker #(.ADDR_W(ADDR_W), .POS_W(POS_W), .POS_LIMIT(POS_LIMIT)) chk_i (
  .clk(clk), .rstN(rstN), .instValid(instValid), .instPc(instPc), .dspPos(dspPos),
  .dspEnable(dspEnable), .outValid(outValid), .brTaken(brTaken), .excDspOff(excDspOff),
  .excResInst(excResInst), .excCause(excCause), .excPc(excPc)
);

// File: tb/posbr_top_tb_top.sv
`timescale 1ns/1ps
module posbr_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [31:0] instWord = '0;
  logic [31:0] instPc = '0;
  logic        compactMode = 1'b0;
  logic [6:0]  dspPos = '0;
  logic        dspEnable = 1'b1;
  logic        outValid, brTaken, excDspOff, excResInst;
  logic [31:0] brTarget, excPc;
  logic [1:0]  excCause;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  localparam logic [31:0] STD_BR = 32'h0418_0000;
  localparam logic [31:0] CMP_BR = 32'h4320_0000;
  localparam logic [31:0] STD_J  = 32'h0800_0000;
  localparam logic [31:0] CMP_J  = 32'hD400_0000;
  localparam logic [31:0] STD_NOP = 32'h0000_0021;
  localparam logic [31:0] CMP_NOP = 32'h0000_0000;

  always #4 clk = ~clk;

  posbr_top dut_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .instPc(instPc), .compactMode(compactMode), .dspPos(dspPos), .dspEnable(dspEnable),
    .outValid(outValid), .brTaken(brTaken), .brTarget(brTarget), .excDspOff(excDspOff),
    .excResInst(excResInst), .excCause(excCause), .excPc(excPc)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Present one instruction, then sample the registered result after the edge.
  task automatic issue(input logic [31:0] w, input logic [31:0] pc, input logic md,
                       input logic [6:0] pos, input logic en);
    @(negedge clk);
    instValid = 1'b1; instWord = w; instPc = pc; compactMode = md; dspPos = pos; dspEnable = en;
    @(posedge clk); #2;
  endtask

  task automatic idle();
    @(negedge clk);
    instValid = 1'b0; instWord = 32'hFFFF_FFFF;
    @(posedge clk); #2;
    chk("R4", "outValid idle", {31'd0, outValid}, 32'd0);
  endtask

  task automatic expectExc(input string req, input logic dsp, input logic ri, input logic [31:0] pc);
    chk(req, "excDspOff", {31'd0, excDspOff}, {31'd0, dsp});
    chk(req, "excResInst", {31'd0, excResInst}, {31'd0, ri});
    chk(req, "excCause", {30'd0, excCause}, dsp ? 32'd1 : (ri ? 32'd2 : 32'd0));
    if (dsp || ri) begin
      chk(req, "excPc", excPc, pc);
      chk("R8", "taken under exception", {31'd0, brTaken}, 32'd0);
    end
  endtask

  // Slot-trap probe: an opener, then the word under test, then a closer.
  task automatic probeCti(input logic [31:0] w, input logic md, input logic expTrap, input string req);
    issue(md ? CMP_J : STD_J, 32'h100, md, 7'd0, 1'b1);
    issue(w, 32'h104, md, 7'd0, 1'b1);
    chk(req, "slot trap", {31'd0, excResInst}, {31'd0, expTrap});
    issue(md ? CMP_NOP : STD_NOP, 32'h108, md, 7'd0, 1'b1);
    issue(md ? CMP_NOP : STD_NOP, 32'h10C, md, 7'd0, 1'b1);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    int offs[6] = '{0, 1, 32'h7FFF, 32'h8000, 32'hFFFF, 32'h1234};
    repeat (3) @(posedge clk);
    #2;
    // R11: reset state
    chk("R11", "outValid", {31'd0, outValid}, 0);
    chk("R11", "brTaken", {31'd0, brTaken}, 0);
    chk("R11", "brTarget", brTarget, 0);
    chk("R11", "excCause", {30'd0, excCause}, 0);
    @(negedge clk); rstN = 1'b1;

    // R1 R2 R3 R12 sweep: every position value, both encodings, several offsets
    for (int md = 0; md < 2; md++) begin
      for (int oi = 0; oi < 6; oi++) begin
        for (int pos = 0; pos < 128; pos++) begin
          logic [31:0] pc, exp;
          int disp;
          pc = (pos % 3 == 0) ? 32'hFFFF_FFF0 : 32'h0040_0000 + pos * 8;
          disp = int'($signed(offs[oi][15:0])) * (md ? 2 : 4);
          exp = pc + 32'd4 + disp;
          issue((md ? CMP_BR : STD_BR) | offs[oi], pc, md[0], pos[6:0], 1'b1);
          chk(md ? "R2" : "R1", "brTarget", brTarget, exp);
          chk("R3", "brTaken", {31'd0, brTaken}, (pos >= 32) ? 32'd1 : 32'd0);
          chk("R4", "outValid", {31'd0, outValid}, 32'd1);
          if (pc == 32'hFFFF_FFF0) chk("R12", "wrapped target", brTarget, exp);
          issue(md ? CMP_NOP : STD_NOP, pc + 4, md[0], 7'd0, 1'b1);
          chk("R6", "nop in slot", {31'd0, excResInst}, 32'd0);
        end
      end
    end

    // R5 back-to-back control transfers
    issue(STD_J, 32'h200, 1'b0, 7'd0, 1'b1);
    expectExc("R5", 0, 0, 0);
    issue(STD_J, 32'h204, 1'b0, 7'd0, 1'b1);
    expectExc("R5", 0, 1, 32'h204);
    // R13 the trapped one opened nothing
    issue(STD_J, 32'h208, 1'b0, 7'd0, 1'b1);
    expectExc("R13", 0, 0, 0);
    // R6 nop closes slot, then branch accepted and taken
    issue(STD_NOP, 32'h20C, 1'b0, 7'd0, 1'b1);
    expectExc("R6", 0, 0, 0);
    issue(STD_BR | 32'h10, 32'h210, 1'b0, 7'd40, 1'b1);
    chk("R6", "branch after closed slot", {31'd0, brTaken}, 32'd1);
    // position branch in slot of the previous branch traps, not taken
    issue(STD_BR, 32'h214, 1'b0, 7'd100, 1'b1);
    expectExc("R5", 0, 1, 32'h214);
    chk("R8", "taken", {31'd0, brTaken}, 32'd0);

    // R5 idle cycles keep slot open
    issue(CMP_J, 32'h300, 1'b1, 7'd0, 1'b1);
    idle(); idle();
    issue(CMP_BR, 32'h304, 1'b1, 7'd50, 1'b1);
    expectExc("R5", 0, 1, 32'h304);
    issue(CMP_NOP, 32'h308, 1'b1, 7'd0, 1'b1);

    // R7 DSP disabled, and priority over slot trap
    issue(STD_BR, 32'h400, 1'b0, 7'd64, 1'b0);
    expectExc("R7", 1, 0, 32'h400);
    issue(STD_J, 32'h404, 1'b0, 7'd0, 1'b1);
    expectExc("R13", 0, 0, 0);
    issue(STD_BR, 32'h408, 1'b0, 7'd64, 1'b0);
    expectExc("R7", 1, 0, 32'h408);
    issue(STD_J, 32'h40C, 1'b0, 7'd0, 1'b1);
    expectExc("R13", 0, 0, 0);
    issue(STD_NOP, 32'h410, 1'b0, 7'd0, 1'b1);

    // R9 standard control-transfer set, R10 compressed set
    probeCti(32'h0000_0008, 1'b0, 1'b1, "R9");
    probeCti(32'h0000_0009, 1'b0, 1'b1, "R9");
    probeCti(32'h0000_0140, 1'b0, 1'b1, "R9");
    probeCti(32'h4200_0018, 1'b0, 1'b1, "R9");
    probeCti(32'h4200_001F, 1'b0, 1'b1, "R9");
    probeCti(32'h4200_0020, 1'b0, 1'b1, "R9");
    probeCti(32'h1000_0000, 1'b0, 1'b1, "R9");
    probeCti(32'h1C00_0000, 1'b0, 1'b1, "R9");
    probeCti(32'h0410_0000, 1'b0, 1'b1, "R9");
    probeCti(STD_NOP, 1'b0, 1'b0, "R9");
    probeCti(32'h4000_0018, 1'b0, 1'b0, "R9");
    probeCti(32'h4000_0000, 1'b1, 1'b1, "R10");
    probeCti(32'h9400_0000, 1'b1, 1'b1, "R10");
    probeCti(32'hD400_0000, 1'b1, 1'b1, "R10");
    probeCti(32'hF400_0000, 1'b1, 1'b1, "R10");
    probeCti(CMP_NOP, 1'b1, 1'b0, "R10");
    probeCti(32'h0800_0000, 1'b1, 1'b0, "R10");

    // R11 reset closes an open slot
    issue(STD_J, 32'h500, 1'b0, 7'd0, 1'b1);
    @(negedge clk); instValid = 1'b0; rstN = 1'b0;
    @(posedge clk); #2;
    chk("R11", "outValid after reset", {31'd0, outValid}, 0);
    @(negedge clk); rstN = 1'b1;
    issue(STD_J, 32'h504, 1'b0, 7'd0, 1'b1);
    expectExc("R11", 0, 0, 0);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule